// File: doc/BRIEF.md
# Idle Clock Gating Controller

This controller governs the low-power idle states of a small processor core. A sleep strobe, qualified by an idle-enable bit, stops the CPU clock while the peripherals keep running from the chosen oscillator: the fast primary source, or the low-frequency secondary one picked by clock-select value 2'b01. The controller drives the two clock gate enables, the oscillator mux select and a primary shutdown request. It also reports which oscillator is live.

A wake event starts a fixed delay, set by a parameter. The CPU clock stays gated for that delay and then resumes on the same source it idled on. All gate changes are taken at instruction-cycle boundaries, which a one-cycle phase strobe marks, so no clipped clock pulses reach the core. A request for the secondary source is refused while that oscillator is disabled.

Top module: `idle_clk_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets run mode on the primary source. After reset, cpu_clk_en=1, per_clk_en=1, osc_mux_sel=0, pri_osc_off=0, pri_run_flag=1 and sec_run_flag=0.
- R2: A sleep strobe with idle_en=1 in run mode is held until the next edge with phase_stb=1. A strobe that coincides with that edge is taken at once. At that edge cpu_clk_en falls and per_clk_en stays on.
- R3: With idle_en=0 at the phase edge, a pending sleep request is dropped and cpu_clk_en stays 1.
- R4: When clk_sel=2'b01 and sec_osc_en=1 at a run-mode phase edge, the secondary source is selected: osc_mux_sel=1, pri_osc_off=1, pri_run_flag=0, sec_run_flag=1. Any other clk_sel value at a run-mode phase edge selects the primary source (osc_mux_sel=0, pri_run_flag=1), and pri_run_flag stays 1 through primary idle and after its wake.
- R5: With clk_sel=2'b01 and sec_osc_en=0 at the phase edge, a sleep request is dropped, cpu_clk_en stays 1 and the source does not change.
- R6: While the secondary source is selected, per_clk_en follows sec_osc_rdy and is 0 while that input is 0.
- R7: A wake event in idle holds cpu_clk_en at 0 for exactly WAKE_CYC cycles when phase_stb is high on every cycle. If phase_stb is absent when the delay ends, cpu_clk_en rises at the next edge with phase_stb=1.
- R8: The source does not change from idle entry through the wake delay, so the core resumes on the oscillator it idled on.
- R9: A wake event during the wake delay, or in run mode, has no effect.
- R10: A sleep strobe during the wake delay is kept. It is taken at the first run-mode phase edge.
- R11: In run mode, a change of clk_sel moves the source only at an edge with phase_stb=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_stb | input | 1 | One-cycle instruction boundary strobe |
| sleep_req | input | 1 | Sleep request strobe |
| idle_en | input | 1 | Sleep enters idle when set |
| clk_sel | input | 2 | Source select, 2'b01 = secondary |
| sec_osc_en | input | 1 | Secondary oscillator enabled |
| sec_osc_rdy | input | 1 | Secondary oscillator running and stable |
| wake_evt | input | 1 | Wake event |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_mux_sel | output | 1 | 0 primary, 1 secondary |
| pri_osc_off | output | 1 | Primary oscillator shutdown request |
| pri_run_flag | output | 1 | Primary source live |
| sec_run_flag | output | 1 | Secondary source live |

## Verification
The collision that matters is a sleep strobe arriving while the wake delay is still counting. The strobe is pulsed mid-delay, and the bench then measures that the core runs for exactly one cycle before it re-enters idle. A second collision is a fresh wake event landing inside the delay; the gated span must still equal WAKE_CYC. Each cycle is also judged against a behavioural reference model, with phase_stb both continuous and sparse.

// File: rtl/idle_ctl_pkg.sv
package idle_ctl_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_IDLE = 2'd1,
        MODE_WAKE = 2'd2
    } mode_e;

    typedef enum logic {
        SRC_PRI = 1'b0,
        SRC_SEC = 1'b1
    } src_e;

    localparam logic [1:0] SEL_SECONDARY = 2'b01;

    typedef struct packed {
        logic cpu_en;
        logic per_en;
        logic mux_sel;
        logic pri_off;
        logic pri_run;
        logic sec_run;
    } gate_out_t;

    function automatic logic sel_wants_sec(input logic [1:0] sel);
        return sel == SEL_SECONDARY;
    endfunction

    function automatic logic sel_refused(input logic [1:0] sel, input logic sec_en);
        return (sel == SEL_SECONDARY) && !sec_en;
    endfunction

endpackage

// File: rtl/idle_wake_timer.sv
module idle_wake_timer #(
    parameter int WAKE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic done
);
    localparam int CW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(WAKE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/idle_mode_fsm.sv
module idle_mode_fsm
    import idle_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  phase_stb,
    input  logic  sleep_req,
    input  logic  idle_en,
    input  logic  refuse,
    input  logic  wake_evt,
    input  logic  timer_done,
    output mode_e mode,
    output logic  timer_load,
    output logic  src_update
);
    mode_e mode_q, mode_d;
    logic  pend_q;
    logic  req_now;

    assign req_now    = pend_q || sleep_req;
    assign src_update = (mode_q == MODE_RUN) && phase_stb;
    assign timer_load = (mode_q == MODE_IDLE) && wake_evt;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN:  if (phase_stb && req_now && idle_en && !refuse) mode_d = MODE_IDLE;
            MODE_IDLE: if (wake_evt) mode_d = MODE_WAKE;
            MODE_WAKE: if (timer_done && phase_stb) mode_d = MODE_RUN;
            default:   mode_d = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RUN;
            pend_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (src_update) begin
                pend_q <= 1'b0;
            end else if (sleep_req && (mode_q != MODE_IDLE)) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign mode = mode_q;
endmodule

// File: rtl/idle_src_sel.sv
module idle_src_sel
    import idle_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        update,
    input  logic [1:0]  clk_sel,
    input  logic        sec_en,
    input  logic        sec_rdy,
    input  logic        cpu_run,
    output gate_out_t   gates
);
    src_e src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= SRC_PRI;
        end else if (update) begin
            if (sel_wants_sec(clk_sel)) begin
                if (sec_en) src_q <= SRC_SEC;
            end else begin
                src_q <= SRC_PRI;
            end
        end
    end

    always_comb begin
        gates.cpu_en  = cpu_run;
        gates.per_en  = (src_q == SRC_PRI) || sec_rdy;
        gates.mux_sel = (src_q == SRC_SEC);
        gates.pri_off = (src_q == SRC_SEC);
        gates.pri_run = (src_q == SRC_PRI);
        gates.sec_run = (src_q == SRC_SEC);
    end
endmodule

// File: rtl/idle_clk_ctrl.sv
module idle_clk_ctrl
    import idle_ctl_pkg::*;
#(
    parameter int WAKE_CYC = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       phase_stb,
    input  logic       sleep_req,
    input  logic       idle_en,
    input  logic [1:0] clk_sel,
    input  logic       sec_osc_en,
    input  logic       sec_osc_rdy,
    input  logic       wake_evt,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_mux_sel,
    output logic       pri_osc_off,
    output logic       pri_run_flag,
    output logic       sec_run_flag
);
    mode_e     mode;
    logic      timer_load, timer_done, src_update;
    gate_out_t gates;

    idle_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .phase_stb  (phase_stb),
        .sleep_req  (sleep_req),
        .idle_en    (idle_en),
        .refuse     (sel_refused(clk_sel, sec_osc_en)),
        .wake_evt   (wake_evt),
        .timer_done (timer_done),
        .mode       (mode),
        .timer_load (timer_load),
        .src_update (src_update)
    );

    idle_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (timer_load),
        .done (timer_done)
    );

    idle_src_sel u_src (
        .clk     (clk),
        .rst     (rst),
        .update  (src_update),
        .clk_sel (clk_sel),
        .sec_en  (sec_osc_en),
        .sec_rdy (sec_osc_rdy),
        .cpu_run (mode == MODE_RUN),
        .gates   (gates)
    );

    assign cpu_clk_en   = gates.cpu_en;
    assign per_clk_en   = gates.per_en;
    assign osc_mux_sel  = gates.mux_sel;
    assign pri_osc_off  = gates.pri_off;
    assign pri_run_flag = gates.pri_run;
    assign sec_run_flag = gates.sec_run;
endmodule

// File: rtl/idle_clk_ctrl_chk.sv
module idle_clk_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       phase_stb,
    input logic       idle_en,
    input logic [1:0] clk_sel,
    input logic       sec_osc_en,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       osc_mux_sel,
    input logic       pri_run_flag,
    input logic       sec_run_flag
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cpu_clk_en && per_clk_en && !osc_mux_sel && pri_run_flag && !sec_run_flag));

    assert_gate_on_phase_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_clk_en) |-> $past(phase_stb));

    assert_no_idle_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && !idle_en) |=> cpu_clk_en);

    assert_refuse_secondary_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && clk_sel == 2'b01 && !sec_osc_en) |=> cpu_clk_en);

    assert_resume_on_phase_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> $past(phase_stb));

    assert_src_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (!cpu_clk_en && $past(!cpu_clk_en)) |-> $stable(osc_mux_sel));
endmodule

bind idle_clk_ctrl idle_clk_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .phase_stb    (phase_stb),
    .idle_en      (idle_en),
    .clk_sel      (clk_sel),
    .sec_osc_en   (sec_osc_en),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .osc_mux_sel  (osc_mux_sel),
    .pri_run_flag (pri_run_flag),
    .sec_run_flag (sec_run_flag)
);

// File: tb/idle_clk_ctrl_tb.sv
module idle_clk_ctrl_tb_top;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic phase_stb = 1'b1;
    logic sleep_req = 1'b0, idle_en = 1'b0, sec_osc_en = 1'b0, sec_osc_rdy = 1'b0, wake_evt = 1'b0;
    logic [1:0] clk_sel = 2'b00;
    logic cpu_clk_en, per_clk_en, osc_mux_sel, pri_osc_off, pri_run_flag, sec_run_flag;

    int errors = 0, checks = 0;
    int phase_per = 1, pc = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    idle_clk_ctrl #(.WAKE_CYC(W)) dut_i (
        .clk(clk), .rst(rst), .phase_stb(phase_stb), .sleep_req(sleep_req),
        .idle_en(idle_en), .clk_sel(clk_sel), .sec_osc_en(sec_osc_en),
        .sec_osc_rdy(sec_osc_rdy), .wake_evt(wake_evt), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_mux_sel(osc_mux_sel), .pri_osc_off(pri_osc_off),
        .pri_run_flag(pri_run_flag), .sec_run_flag(sec_run_flag)
    );

    always @(negedge clk) begin
        pc <= pc + 1;
        phase_stb <= ((pc % phase_per) == 0);
    end

    // Behavioural reference: 0 run, 1 idle, 2 waking
    int ms = 0, mel = 0;
    bit mpend = 0, msrc = 0;
    always @(posedge clk) begin
        if (rst) begin
            ms = 0; mel = 0; mpend = 0; msrc = 0;
        end else begin
            case (ms)
                0: if (phase_stb) begin
                       if (clk_sel == 2'b01) begin
                           if (sec_osc_en) msrc = 1;
                       end else msrc = 0;
                       if ((mpend || sleep_req) && idle_en && !(clk_sel == 2'b01 && !sec_osc_en)) ms = 1;
                       mpend = 0;
                   end else if (sleep_req) mpend = 1;
                1: if (wake_evt) begin ms = 2; mel = 0; end
                default: begin
                    if (sleep_req) mpend = 1;
                    if (mel >= W - 1 && phase_stb) ms = 0;
                    else if (mel < W - 1) mel++;
                end
            endcase
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        chk(cur_req, "cpu_clk_en", cpu_clk_en, ms == 0);
        chk(cur_req, "per_clk_en", per_clk_en, (msrc == 0) || sec_osc_rdy);
        chk(cur_req, "osc_mux_sel", osc_mux_sel, msrc);
        chk(cur_req, "pri_osc_off", pri_osc_off, msrc);
        chk(cur_req, "pri_run_flag", pri_run_flag, !msrc);
        chk(cur_req, "sec_run_flag", sec_run_flag, msrc);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1; cyc(); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_evt = 1'b1; cyc(); wake_evt = 1'b0;
    endtask

    task automatic count_gated(string req, int exp);
        int n = 0;
        wake_evt = 1'b1;
        do begin
            cyc(); wake_evt = 1'b0;
            if (!cpu_clk_en) n++;
            if (n == 3 && req == "R9") wake_evt = 1'b1;
        end while (!cpu_clk_en && n < 100);
        wake_evt = 1'b0;
        chk(req, "gated cycles", n, exp);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        run(3);
        rst = 1'b0;
        cur_req = "R1"; cyc();
        chk("R1", "reset cpu", cpu_clk_en, 1);
        chk("R1", "reset pri flag", pri_run_flag, 1);

        // R3: idle disabled
        cur_req = "R3"; idle_en = 0; pulse_sleep(); run(3);
        chk("R3", "cpu stays on", cpu_clk_en, 1);

        // R2/R4: primary idle, wake delay R7, same source R8
        cur_req = "R2"; idle_en = 1; clk_sel = 2'b00; pulse_sleep(); run(2);
        chk("R2", "cpu gated", cpu_clk_en, 0);
        chk("R4", "pri flag in idle", pri_run_flag, 1);
        cur_req = "R7"; count_gated("R7", W);
        chk("R8", "mux after wake", osc_mux_sel, 0);
        chk("R4", "pri flag after wake", pri_run_flag, 1);

        // R9: wake in run ignored, wake inside delay ignored
        cur_req = "R9"; pulse_wake(); run(2);
        chk("R9", "run wake ignored", cpu_clk_en, 1);
        pulse_sleep(); run(2);
        count_gated("R9", W);

        // R11: sparse phase strobe, source switch only at strobes
        cur_req = "R11"; phase_per = 4; run(4);
        sec_osc_en = 1; sec_osc_rdy = 1; clk_sel = 2'b01; run(8);
        chk("R4", "secondary selected", sec_run_flag, 1);
        chk("R4", "primary shut", pri_osc_off, 1);

        // secondary idle, R6 ready gating, R7 sparse, R8
        cur_req = "R6"; pulse_sleep(); run(6);
        sec_osc_rdy = 0; run(2);
        chk("R6", "per gated", per_clk_en, 0);
        sec_osc_rdy = 1; run(2);
        cur_req = "R7"; pulse_wake(); run(W + 6);
        chk("R7", "cpu resumed", cpu_clk_en, 1);
        chk("R8", "still secondary", osc_mux_sel, 1);

        // R5: refuse secondary when disabled
        cur_req = "R5"; phase_per = 1; clk_sel = 2'b00; run(3);
        clk_sel = 2'b01; sec_osc_en = 0; pulse_sleep(); run(3);
        chk("R5", "cpu stays on", cpu_clk_en, 1);
        chk("R5", "source unchanged", osc_mux_sel, 0);

        // R10: sleep during delay is deferred to run mode
        cur_req = "R10"; clk_sel = 2'b00; run(2);
        pulse_sleep(); run(2);
        pulse_wake(); run(2);
        pulse_sleep();
        begin
            int hi = 0;
            int guard = 0;
            while (!cpu_clk_en && guard < 50) begin cyc(); guard++; end
            while (cpu_clk_en && guard < 50) begin hi++; cyc(); guard++; end
            chk("R10", "run cycles before re-idle", hi, 1);
        end
        run(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule